// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block walks an SDRAM controller through its power-up ritual after the memory window has been configured. On a start pulse it first disables periodic refresh by writing a zero refresh rate, then issues a fixed series of commands through a command-issue port, each as a 3-bit code with a one-cycle strobe. Refresh is re-enabled with its programmed rate only after the last command, and a one-cycle done pulse marks the end.

The series is NOP, precharge-all and one auto-refresh, each followed by a programmable wait. Eight auto-refreshes follow in consecutive cycles. A mode-set command for CAS latency 2 and another wait come next, and the normal-operation command closes the series. The wait length is a parameter, so a bench can shorten the long power-up delay. The region base and boundary inputs are the configuration the sequencer depends on. A start is honoured only when the boundary lies above the base, and it is ignored while a sequence is running.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `cmd_stb`, `cmd_code`, `rfr_wr`, `rfr_val` and `done` are all zero.
- R2: A start accepted in idle makes `rfr_wr` pulse with `rfr_val` = 0 in the cycle after the start edge. No command strobe comes before it.
- R3: Command codes are NOP = 1, PRECHARGE = 2, AUTO_REFRESH = 3, MODE_CAS2 = 4 and NORMAL = 5. `cmd_code` reads 0 in every cycle without `cmd_stb`.
- R4: NOP follows the zero-rate write by one cycle. PRECHARGE follows NOP, and one AUTO_REFRESH follows PRECHARGE, each DELAY_CYC cycles after the strobe before it.
- R5: DELAY_CYC cycles after that single AUTO_REFRESH, a burst of BURST_N (default 8) AUTO_REFRESH strobes is issued in consecutive cycles.
- R6: MODE_CAS2 is strobed in the cycle after the burst. NORMAL follows it DELAY_CYC cycles later, and no strobe occurs between them.
- R7: In the cycle after NORMAL, `rfr_wr` pulses with `rfr_val` = RFR_INIT. `rfr_val` holds its last written value at all other times.
- R8: `done` pulses for exactly one cycle, in the cycle after the RFR_INIT write. A start presented in that cycle begins a new sequence.
- R9: A start while a sequence is running has no effect on the timing or content of the outputs.
- R10: A start while `cfg_bound` is not greater than `cfg_base` is ignored, and no strobe of any kind follows.
- R11: At most one of `cmd_stb`, `rfr_wr` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the power-up sequence |
| cfg_base | input | ADDR_W | Programmed region base |
| cfg_bound | input | ADDR_W | Programmed region boundary; must exceed base |
| cmd_code | output | 3 | Command code, valid with cmd_stb |
| cmd_stb | output | 1 | One-cycle command strobe |
| rfr_val | output | RFR_W | Refresh-rate value |
| rfr_wr | output | 1 | One-cycle refresh-rate write strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check on every cycle that strobes never coincide, that the command code is zero when not strobed, that NORMAL is followed directly by the refresh-rate write and that done is a single pulse following it. They also check that mode-set is followed by a quiet gap, that the wait counter stays in range and that the step index never moves backwards under a stray start. Only the bench scenarios can show the whole cycle-exact timeline. That includes the DELAY_CYC spacings, the contiguous burst, the rejection of a start with a bad configuration, the immunity to starts during a run, and the restart from the done cycle.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_NOP       = 3'd1,
    CMD_PRECHARGE = 3'd2,
    CMD_AUTO_REF  = 3'd3,
    CMD_MODE_CAS2 = 3'd4,
    CMD_NORMAL    = 3'd5
  } sdram_cmd_e;

  typedef enum logic [1:0] {
    ACT_CMD     = 2'd0,
    ACT_RFR_OFF = 2'd1,
    ACT_RFR_ON  = 2'd2
  } step_act_e;

  typedef struct packed {
    step_act_e  act;
    sdram_cmd_e cmd;
    logic       pause;
    logic       last;
  } step_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } seq_state_e;

endpackage

// File: rtl/sdram_init_steps.sv
module sdram_init_steps
  import sdram_init_pkg::*;
#(
  parameter int BURST_N = 8,
  parameter int STEP_W  = $clog2(BURST_N + 8)
) (
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);
  localparam logic [STEP_W-1:0] IDX_RFR0  = STEP_W'(0);
  localparam logic [STEP_W-1:0] IDX_NOP   = STEP_W'(1);
  localparam logic [STEP_W-1:0] IDX_PRE   = STEP_W'(2);
  localparam logic [STEP_W-1:0] IDX_AREF  = STEP_W'(3);
  localparam logic [STEP_W-1:0] IDX_B_LO  = STEP_W'(4);
  localparam logic [STEP_W-1:0] IDX_B_HI  = STEP_W'(4 + BURST_N - 1);
  localparam logic [STEP_W-1:0] IDX_MODE  = STEP_W'(4 + BURST_N);
  localparam logic [STEP_W-1:0] IDX_NORM  = STEP_W'(5 + BURST_N);

  always_comb begin
    step = '{act: ACT_CMD, cmd: CMD_NONE, pause: 1'b0, last: 1'b0};
    if (idx == IDX_RFR0) begin
      step.act = ACT_RFR_OFF;
    end else if (idx == IDX_NOP) begin
      step.cmd   = CMD_NOP;
      step.pause = 1'b1;
    end else if (idx == IDX_PRE) begin
      step.cmd   = CMD_PRECHARGE;
      step.pause = 1'b1;
    end else if (idx == IDX_AREF) begin
      step.cmd   = CMD_AUTO_REF;
      step.pause = 1'b1;
    end else if (idx >= IDX_B_LO && idx <= IDX_B_HI) begin
      step.cmd = CMD_AUTO_REF;
    end else if (idx == IDX_MODE) begin
      step.cmd   = CMD_MODE_CAS2;
      step.pause = 1'b1;
    end else if (idx == IDX_NORM) begin
      step.cmd = CMD_NORMAL;
    end else begin
      step.act  = ACT_RFR_ON;
      step.last = 1'b1;
    end
  end
endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int DELAY_CYC = 16384,
  parameter int CNT_W     = (DELAY_CYC > 2) ? $clog2(DELAY_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DELAY_CYC - 2);

  logic [CNT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= LOAD_VAL;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign expired = active && (cnt == '0);

  // R4: the wait counter never exceeds its load value
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
    active |-> cnt <= LOAD_VAL);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              RFR_W     = 16,
  parameter logic [RFR_W-1:0] RFR_INIT = 16'h0300,
  parameter int              DELAY_CYC = 16384,
  parameter int              BURST_N   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_bound,
  output logic [2:0]        cmd_code,
  output logic              cmd_stb,
  output logic [RFR_W-1:0]  rfr_val,
  output logic              rfr_wr,
  output logic              done
);
  localparam int STEP_W = $clog2(BURST_N + 8);

  seq_state_e        state;
  logic [STEP_W-1:0] step_idx;
  step_t             cur;
  logic              tmr_load;
  logic              tmr_exp;
  logic              cfg_ok;

  assign cfg_ok = cfg_bound > cfg_base;

  sdram_init_steps #(.BURST_N(BURST_N), .STEP_W(STEP_W)) u_steps (
    .idx  (step_idx),
    .step (cur)
  );

  sdram_init_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .expired (tmr_exp)
  );

  assign tmr_load = (state == ST_RUN) && cur.pause;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      step_idx <= '0;
      cmd_code <= 3'd0;
      cmd_stb  <= 1'b0;
      rfr_val  <= '0;
      rfr_wr   <= 1'b0;
      done     <= 1'b0;
    end else begin
      cmd_code <= 3'd0;
      cmd_stb  <= 1'b0;
      rfr_wr   <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start && cfg_ok) begin
            state    <= ST_RUN;
            step_idx <= '0;
          end
        end
        ST_RUN: begin
          unique case (cur.act)
            ACT_RFR_OFF: begin
              rfr_wr  <= 1'b1;
              rfr_val <= '0;
            end
            ACT_RFR_ON: begin
              rfr_wr  <= 1'b1;
              rfr_val <= RFR_INIT;
            end
            default: begin
              cmd_stb  <= 1'b1;
              cmd_code <= cur.cmd;
            end
          endcase
          if (cur.last) begin
            state <= ST_FINISH;
          end else begin
            step_idx <= step_idx + 1'b1;
            if (cur.pause) state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tmr_exp) state <= ST_RUN;
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // R11: strobes never coincide
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({cmd_stb, rfr_wr, done}) <= 1);

  // R3: idle code is zero
  a_r3_idle_code: assert property (@(posedge clk) disable iff (rst)
    !cmd_stb |-> cmd_code == 3'd0);

  // R7: NORMAL is followed by the initial refresh-rate write
  a_r7_rfr_after_normal: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_code == CMD_NORMAL) |=> (rfr_wr && rfr_val == RFR_INIT));

  // R6: mode set is followed by a quiet cycle
  a_r6_mode_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_code == CMD_MODE_CAS2) |=> !cmd_stb);

  // R8: done is one cycle long and follows a refresh-rate write
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_after_rfr: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rfr_wr));

  // R9: a start during a run never rewinds the step index
  a_r9_no_rewind: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> step_idx >= $past(step_idx));
endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int         D     = 16;
  localparam int         BN    = 8;
  localparam logic [15:0] RINIT = 16'h0123;
  localparam int         LAST  = 2 + 4*D + 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cfg_base = 32'h1000_0000;
  logic [31:0] cfg_bound = 32'h2000_0000;
  logic [2:0]  cmd_code;
  logic        cmd_stb;
  logic [15:0] rfr_val;
  logic        rfr_wr;
  logic        done;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sdram_init_seq #(.ADDR_W(32), .RFR_W(16), .RFR_INIT(RINIT),
                   .DELAY_CYC(D), .BURST_N(BN)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base),
    .cfg_bound(cfg_bound), .cmd_code(cmd_code), .cmd_stb(cmd_stb),
    .rfr_val(rfr_val), .rfr_wr(rfr_wr), .done(done));

  // event kinds: 0 none, 1 rate zero, 2 rate init, 3 done, 8+code command
  function automatic int exp_kind(input int i);
    int b0;
    b0 = 2 + 3*D;
    if (i == 1) return 1;
    if (i == 2) return 8 + 1;
    if (i == 2 + D) return 8 + 2;
    if (i == 2 + 2*D) return 8 + 3;
    if (i >= b0 && i < b0 + BN) return 8 + 3;
    if (i == b0 + BN) return 8 + 4;
    if (i == 2 + 4*D + 8) return 8 + 5;
    if (i == 2 + 4*D + 9) return 2;
    if (i == LAST) return 3;
    return 0;
  endfunction

  function automatic string req_of(input int k);
    case (k)
      0: return "R3";
      1: return "R2";
      2: return "R7";
      3: return "R8";
      9, 10: return "R4";
      11: return "R5";
      12, 13: return "R6";
      default: return "R11";
    endcase
  endfunction

  function automatic int obs_kind();
    int n;
    n = int'(cmd_stb) + int'(rfr_wr) + int'(done);
    if (n > 1) return 15;
    if (cmd_stb) return 8 + int'(cmd_code);
    if (rfr_wr) return (rfr_val == 16'h0) ? 1 : ((rfr_val == RINIT) ? 2 : 7);
    if (done) return 3;
    if (cmd_code != 3'd0) return 14;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // runs one sequence; inject != 0 pulses start during the run (R9)
  task automatic run_seq(input bit inject, input string tag);
    int miss;
    miss = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= LAST; i++) begin
      @(negedge clk);
      begin
        int e;
        int o;
        e = exp_kind(i);
        o = obs_kind();
        if (o != e) miss++;
        check(o == e, req_of(e), {tag, " event kind"}, o, e);
        if (e == 2) check(rfr_val == RINIT, "R7", "rate value", int'(rfr_val), int'(RINIT));
      end
      if (inject && (i == 5 || i == 2 + 3*D + 3 || i == 2 + 4*D + 8)) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (inject) check(miss == 0, "R9", "mismatches with start during run", miss, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!cmd_stb && cmd_code == 0 && !rfr_wr && rfr_val == 0 && !done,
          "R1", "outputs in reset", obs_kind(), 0);
    rst = 1'b0;
    @(negedge clk);
    check(obs_kind() == 0 && rfr_val == 0, "R1", "outputs after reset", obs_kind(), 0);
  endtask

  task automatic t_quiet(input int n, input string req);
    int hits;
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (obs_kind() != 0) hits++;
    end
    check(hits == 0, req, "unexpected strobes", hits, 0);
  endtask

  task automatic t_bad_cfg();
    cfg_bound = cfg_base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t_quiet(20, "R10");
    cfg_bound = cfg_base - 32'h1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t_quiet(20, "R10");
    check(rfr_val == RINIT, "R7", "rate held after ignored start", int'(rfr_val), int'(RINIT));
    cfg_bound = 32'h2000_0000;
  endtask

  initial begin
    t_reset();
    run_seq(1'b0, "basic");
    t_quiet(10, "R8");
    check(rfr_val == RINIT, "R7", "rate held after run", int'(rfr_val), int'(RINIT));
    run_seq(1'b1, "busy start");
    t_quiet(5, "R8");
    t_bad_cfg();
    run_seq(1'b0, "chain first");
    run_seq(1'b0, "chain from done");
    t_quiet(5, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule